// File: doc/BRIEF.md
# GPIO Edge-Detect Interrupt Unit

This block watches 28 asynchronous general-purpose input lines and records qualifying transitions in a sticky edge-status register. For every line, software chooses whether a rising edge, a falling edge, either edge or no edge is recorded. It does this through two per-line enable registers on a small single-cycle register bus. Each status bit stays set until software writes a one to it.

The eight lowest status bits drive their own interrupt lines. All 28 status bits are ORed into a summary interrupt. A wake mask selects which recorded edges also raise a wake request.

Each input passes through a two-flop synchronizer. An edge is found by comparing the synchronized value with its value one cycle earlier. If a new edge and a clearing write hit the same bit in the same cycle, the new edge is kept.

Top module: `gpio_edge_irq`

## Requirements
- R1: After reset, the rise-enable, fall-enable, status and wake-mask registers all read zero, and every interrupt and wake output is low.
- R2: A 0-to-1 transition on a line sets that line's status bit only when its rise-enable bit is 1. A 1-to-0 transition has no effect when only the rise-enable bit is set.
- R3: A 1-to-0 transition on a line sets that line's status bit only when its fall-enable bit is 1.
- R4: With both enable bits set, either edge sets the status bit. With both enable bits clear, no edge on that line is recorded.
- R5: Writing a 1 to a status bit clears it, and writing a 0 leaves it unchanged. Writing 0x0FFFFFFF clears every bit. Bits 31:28 of every register read as zero and ignore writes.
- R6: When an edge and a clearing write reach the same status bit in the same cycle, the bit ends up set.
- R7: Output irq_line[i] is high exactly when status bit i is set, for i from 0 to 7.
- R8: Output irq_summary is high exactly when any of the 28 status bits is set.
- R9: Output wake_req is high exactly when some status bit is set whose wake-mask bit is also 1.
- R10: The status bit becomes set on the third rising clock edge after the input changes. After only two edges it is still clear.
- R11: The byte offsets are: rise-enable 0x00, fall-enable 0x04, status 0x08, wake mask 0x0C. Any other offset reads zero and ignores writes. Reads return data combinationally in the cycle bus_en is high. Writes take effect at the clock edge where bus_en and bus_we are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_en is high |
| gpio_in | input | 28 | Asynchronous input lines |
| irq_line | output | 8 | Per-line interrupts for lines 0 to 7 |
| irq_summary | output | 1 | OR of all status bits |
| wake_req | output | 1 | OR of status bits selected by the wake mask |

## Verification
The hardest situation to reach is a new edge and a clearing write landing on the same status bit in the same clock cycle. The edge only reaches the status register after the synchronizer and the compare flop. The bench therefore changes the input at a falling clock edge and waits exactly two more falling edges. It then issues the status write, so the write is sampled at the same rising edge as the edge. The same counting gives a read between the second and third edges, which shows that the bit is still clear there. A sweep then covers every line against each of the four enable combinations and both edge directions.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

  localparam logic [7:0] OFS_RISE = 8'h00;
  localparam logic [7:0] OFS_FALL = 8'h04;
  localparam logic [7:0] OFS_STAT = 8'h08;
  localparam logic [7:0] OFS_WAKE = 8'h0C;

  typedef enum logic [2:0] {
    SEL_RISE,
    SEL_FALL,
    SEL_STAT,
    SEL_WAKE,
    SEL_NONE
  } reg_sel_e;

endpackage

// File: rtl/gpio_edge_sync.sv
module gpio_edge_sync #(
  parameter int unsigned WIDTH  = 28,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);

  logic [STAGES-1:0][WIDTH-1:0] chain_q;
  logic [STAGES-1:0][WIDTH-1:0] chain_d;

  always_comb begin
    chain_d[0] = async_in;
    for (int s = 1; s < STAGES; s++) begin
      chain_d[s] = chain_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect #(
  parameter int unsigned WIDTH = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] level_in,
  input  logic [WIDTH-1:0] rise_en,
  input  logic [WIDTH-1:0] fall_en,
  output logic [WIDTH-1:0] edge_hit
);

  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] prev_d;
  logic [WIDTH-1:0] went_up;
  logic [WIDTH-1:0] went_down;

  always_comb begin
    prev_d    = level_in;
    went_up   = level_in & ~prev_q;
    went_down = ~level_in & prev_q;
    edge_hit  = (went_up & rise_en) | (went_down & fall_en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
    end else begin
      prev_q <= prev_d;
    end
  end

endmodule

// File: rtl/gpio_edge_regs.sv
module gpio_edge_regs
  import gpio_edge_pkg::*;
#(
  parameter int unsigned NUM_LINES = 28,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_en,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic [NUM_LINES-1:0] edge_hit,
  output logic [NUM_LINES-1:0] rise_en,
  output logic [NUM_LINES-1:0] fall_en,
  output logic [NUM_LINES-1:0] wake_en,
  output logic [NUM_LINES-1:0] status
);

  localparam int unsigned PAD_W = DATA_W - NUM_LINES;

  reg_sel_e             sel;
  logic                 wr_go;
  logic [NUM_LINES-1:0] wr_bits;
  logic [NUM_LINES-1:0] clr_bits;

  logic [NUM_LINES-1:0] rise_q, rise_d;
  logic [NUM_LINES-1:0] fall_q, fall_d;
  logic [NUM_LINES-1:0] wake_q, wake_d;
  logic [NUM_LINES-1:0] stat_q, stat_d;
  logic                 rise_ce, fall_ce, wake_ce, stat_ce;
  logic [NUM_LINES-1:0] rd_bits;

  always_comb begin
    if      (bus_addr == OFS_RISE[ADDR_W-1:0]) sel = SEL_RISE;
    else if (bus_addr == OFS_FALL[ADDR_W-1:0]) sel = SEL_FALL;
    else if (bus_addr == OFS_STAT[ADDR_W-1:0]) sel = SEL_STAT;
    else if (bus_addr == OFS_WAKE[ADDR_W-1:0]) sel = SEL_WAKE;
    else                                       sel = SEL_NONE;
  end

  always_comb begin
    wr_go    = bus_en && bus_we;
    wr_bits  = bus_wdata[NUM_LINES-1:0];
    rise_ce  = wr_go && (sel == SEL_RISE);
    fall_ce  = wr_go && (sel == SEL_FALL);
    wake_ce  = wr_go && (sel == SEL_WAKE);
    clr_bits = (wr_go && (sel == SEL_STAT)) ? wr_bits : '0;
    stat_ce  = (|clr_bits) || (|edge_hit);
    rise_d   = wr_bits;
    fall_d   = wr_bits;
    wake_d   = wr_bits;
    stat_d   = (stat_q & ~clr_bits) | edge_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q <= '0;
      fall_q <= '0;
      wake_q <= '0;
      stat_q <= '0;
    end else begin
      if (rise_ce) rise_q <= rise_d;
      if (fall_ce) fall_q <= fall_d;
      if (wake_ce) wake_q <= wake_d;
      if (stat_ce) stat_q <= stat_d;
    end
  end

  always_comb begin
    unique case (sel)
      SEL_RISE: rd_bits = rise_q;
      SEL_FALL: rd_bits = fall_q;
      SEL_STAT: rd_bits = stat_q;
      SEL_WAKE: rd_bits = wake_q;
      default:  rd_bits = '0;
    endcase
    bus_rdata = bus_en ? {{PAD_W{1'b0}}, rd_bits} : '0;
  end

  assign rise_en = rise_q;
  assign fall_en = fall_q;
  assign wake_en = wake_q;
  assign status  = stat_q;

endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
  parameter int unsigned NUM_LINES   = 28,
  parameter int unsigned NUM_DIRECT  = 8,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_en,
  input  logic                  bus_we,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  input  logic [NUM_LINES-1:0]  gpio_in,
  output logic [NUM_DIRECT-1:0] irq_line,
  output logic                  irq_summary,
  output logic                  wake_req
);

  logic [1:0]           rst_pipe_q;
  logic                 core_rst_n;
  logic [NUM_LINES-1:0] level_sync;
  logic [NUM_LINES-1:0] rise_en;
  logic [NUM_LINES-1:0] fall_en;
  logic [NUM_LINES-1:0] wake_en;
  logic [NUM_LINES-1:0] edge_hit;
  logic [NUM_LINES-1:0] status_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign core_rst_n = rst_pipe_q[1];

  gpio_edge_sync #(
    .WIDTH  (NUM_LINES),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .async_in (gpio_in),
    .sync_out (level_sync)
  );

  gpio_edge_detect #(
    .WIDTH (NUM_LINES)
  ) u_detect (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .level_in (level_sync),
    .rise_en  (rise_en),
    .fall_en  (fall_en),
    .edge_hit (edge_hit)
  );

  gpio_edge_regs #(
    .NUM_LINES (NUM_LINES),
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .edge_hit  (edge_hit),
    .rise_en   (rise_en),
    .fall_en   (fall_en),
    .wake_en   (wake_en),
    .status    (status_q)
  );

  assign irq_line    = status_q[NUM_DIRECT-1:0];
  assign irq_summary = |status_q;
  assign wake_req    = |(status_q & wake_en);

endmodule

// File: rtl/gpio_edge_irq_chk.sv
module gpio_edge_irq_chk #(
  parameter int unsigned NUM_LINES = 28,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_en,
  input logic                 bus_we,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [DATA_W-1:0]    bus_wdata,
  input logic [DATA_W-1:0]    bus_rdata,
  input logic [NUM_LINES-1:0] status,
  input logic [NUM_LINES-1:0] edge_hit,
  input logic [NUM_LINES-1:0] rise_en,
  input logic [NUM_LINES-1:0] fall_en
);

  logic [NUM_LINES-1:0] clr_req;
  assign clr_req = (bus_en && bus_we && (bus_addr == ADDR_W'(8'h08)))
                   ? bus_wdata[NUM_LINES-1:0] : '0;

  AST_NO_UNCAUSED_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & ~$past(status) & ~$past(edge_hit)) == '0)); // R2

  AST_CLEAR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(status) & ~status & ~$past(clr_req)) == '0)); // R5

  AST_HIT_NOT_LOST: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_hit != '0) |=> ((status & $past(edge_hit)) == $past(edge_hit))); // R6

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((edge_hit & ~(rise_en | fall_en)) == '0)); // R4

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata[DATA_W-1:NUM_LINES] == '0)); // R5

endmodule

bind gpio_edge_irq gpio_edge_irq_chk #(
  .NUM_LINES (NUM_LINES),
  .DATA_W    (DATA_W),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_en    (bus_en),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .status    (status_q),
  .edge_hit  (edge_hit),
  .rise_en   (rise_en),
  .fall_en   (fall_en)
);

// File: tb/gpio_edge_irq_test.sv
`timescale 1ns/1ps
module gpio_edge_irq_test;

  localparam logic [31:0] WAKE_PAT = 32'h0AAAAAAA;
  localparam logic [31:0] ALL_ONES = 32'h0FFFFFFF;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_en, bus_we;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [27:0] gpio_in;
  logic [7:0]  irq_line;
  logic        irq_summary, wake_req;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  gpio_edge_irq uut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .gpio_in(gpio_in), .irq_line(irq_line), .irq_summary(irq_summary),
    .wake_req(wake_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic reg_read(input logic [4:0] a, output logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_en = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic [31:0] exp;
    rst_n = 1'b0; bus_en = 1'b0; bus_we = 1'b0; bus_addr = '0;
    bus_wdata = '0; gpio_in = '0;
    settle(5);
    rst_n = 1'b1;
    settle(4);

    // R1 reset state
    reg_read(5'h00, rd); chk("R1 rise", rd, 0);
    reg_read(5'h04, rd); chk("R1 fall", rd, 0);
    reg_read(5'h08, rd); chk("R1 status", rd, 0);
    reg_read(5'h0C, rd); chk("R1 wake", rd, 0);
    chk("R1 outputs", {22'd0, irq_line, irq_summary, wake_req}, 0);

    // R5 upper bits, R11 unmapped offset
    reg_write(5'h00, 32'hFFFFFFFF);
    reg_read(5'h00, rd); chk("R5 upper bits", rd, ALL_ONES);
    reg_write(5'h10, 32'h12345678);
    reg_read(5'h10, rd); chk("R11 unmapped read", rd, 0);
    reg_read(5'h00, rd); chk("R11 unmapped write", rd, ALL_ONES);
    reg_write(5'h04, 32'h00000055);
    reg_read(5'h04, rd); chk("R11 fall offset", rd, 32'h55);
    reg_write(5'h04, 0);

    // R2 multi-line rise, fall ignored
    gpio_in = 28'h5A5A5A5;
    settle(3);
    reg_read(5'h08, rd); chk("R2 multi rise", rd, 32'h05A5A5A5);
    chk("R7 direct lines", {24'd0, irq_line}, 32'hA5);
    chk("R8 summary", {31'd0, irq_summary}, 1);
    gpio_in = '0;
    settle(4);
    reg_read(5'h08, rd); chk("R2 fall ignored", rd, 32'h05A5A5A5);
    reg_write(5'h08, 32'h000000F0);
    reg_read(5'h08, rd); chk("R5 partial clear", rd, 32'h05A5A505);
    reg_write(5'h08, 0);
    reg_read(5'h08, rd); chk("R5 zero write", rd, 32'h05A5A505);
    reg_write(5'h08, ALL_ONES);
    reg_read(5'h08, rd); chk("R5 clear all", rd, 0);
    chk("R8 summary low", {31'd0, irq_summary}, 0);

    // R10 latency, line 3
    gpio_in[3] = 1'b1;
    settle(2);
    reg_read(5'h08, rd); chk("R10 not yet", rd, 0);
    reg_read(5'h08, rd); chk("R10 third edge", rd, 32'h8);
    reg_write(5'h08, ALL_ONES);
    reg_write(5'h00, 0);
    gpio_in[3] = 1'b0;
    settle(4);

    // R6 set wins over clear, line 5
    reg_write(5'h00, 32'h20);
    reg_write(5'h04, 32'h20);
    gpio_in[5] = 1'b1;
    settle(3);
    reg_read(5'h08, rd); chk("R6 first edge", rd, 32'h20);
    gpio_in[5] = 1'b0;
    settle(2);
    reg_write(5'h08, 32'h20);
    reg_read(5'h08, rd); chk("R6 set wins", rd, 32'h20);
    reg_write(5'h08, 32'h20);
    reg_read(5'h08, rd); chk("R6 later clear", rd, 0);
    reg_write(5'h00, 0);
    reg_write(5'h04, 0);

    // Sweep: every line, every enable pair, both directions
    reg_write(5'h0C, WAKE_PAT);
    for (int l = 0; l < 28; l++) begin
      for (int m = 0; m < 4; m++) begin
        for (int d = 0; d < 2; d++) begin
          string tag;
          if (d == 1) begin
            gpio_in[l] = 1'b1;
            settle(4);
          end
          reg_write(5'h00, m[0] ? (32'h1 << l) : 32'h0);
          reg_write(5'h04, m[1] ? (32'h1 << l) : 32'h0);
          gpio_in[l] = ~gpio_in[l];
          settle(3);
          exp = ((d == 0) ? m[0] : m[1]) ? (32'h1 << l) : 32'h0;
          if (m == 0 || m == 3) tag = "R4 sweep";
          else if (d == 0)      tag = "R2 sweep";
          else                  tag = "R3 sweep";
          reg_read(5'h08, rd); chk(tag, rd, exp);
          chk("R7 sweep", {24'd0, irq_line}, {24'd0, exp[7:0]});
          chk("R8 sweep", {31'd0, irq_summary}, {31'd0, exp != 0});
          chk("R9 sweep", {31'd0, wake_req}, {31'd0, (exp & WAKE_PAT) != 0});
          reg_write(5'h00, 0);
          reg_write(5'h04, 0);
          gpio_in[l] = 1'b0;
          settle(4);
          reg_write(5'h08, ALL_ONES);
          reg_read(5'h08, rd); chk("R5 sweep clear", rd, 0);
        end
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule